// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset, into a physical address. It holds a small segment table on chip. Every entry stores a starting physical address (the base), a segment length, a valid flag and three access-right bits. A lookup adds the offset to the base of the selected entry, but only after four checks pass. The first check is the number of live segments. The second is the entry's valid flag. The third is the length bound. The fourth is the rights for the requested kind of access. When a check fails, the block returns a two-bit code that names the first check that failed and does not return an address.

Software-side logic loads the table through a write port. It writes one entry per cycle and, separately, writes a count register that says how many segment numbers are in use. A request is one cycle wide, marked by `req_valid`. The answer appears on the registered response outputs exactly one clock later. A new request may be issued on every cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset the response outputs are all zero, the segment count is 0 and every entry is invalid, so any request made before configuration faults with code 2'b01.
- R2: A request sampled on a rising edge gives `rsp_valid` = 1 after that same edge. A cycle without a request gives `rsp_valid` = 0, `rsp_fault` = 2'b00 and `rsp_paddr` = 0.
- R3: When all checks pass, `rsp_fault` = 2'b00 and `rsp_paddr` = base + offset, computed one bit wider than the base so that the sum never wraps.
- R4: A segment number greater than or equal to the segment count register faults with code 2'b01, whatever the contents of the entry.
- R5: A segment number below the count whose entry has its valid flag at 0 faults with code 2'b01.
- R6: An offset greater than or equal to the entry length faults with code 2'b10. An offset of length-1 is legal.
- R7: The access type is 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. Read needs rights bit 0, write needs bit 1 and execute needs bit 2. A missing right, or the reserved type, faults with code 2'b11.
- R8: When several checks fail, the reported code is the first in the order segment (2'b01), offset (2'b10), rights (2'b11).
- R9: Any faulted response drives `rsp_paddr` to 0.
- R10: `ent_we` stores base, length, valid flag and rights into entry `ent_idx` on the clock edge. `tlen_we` loads the segment count. A lookup made on the same edge as a write uses the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ent_we | input | 1 | Write one table entry |
| ent_idx | input | SEG_W (3) | Entry to write |
| ent_base | input | BASE_W (16) | Base physical address to store |
| ent_len | input | LEN_W (16) | Segment length to store |
| ent_valid | input | 1 | Valid flag to store |
| ent_perm | input | 3 | Rights to store: bit0 read, bit1 write, bit2 execute |
| tlen_we | input | 1 | Write the segment count register |
| tlen_val | input | SEG_W+1 (4) | New segment count |
| req_valid | input | 1 | Lookup request this cycle |
| req_seg | input | SEG_W (3) | Segment number |
| req_ofs | input | LEN_W (16) | Offset inside the segment |
| req_acc | input | 2 | Access type |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | BASE_W+1 (17) | Translated physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 ok, 01 bad segment, 10 offset bound, 11 rights |

## Verification
Table state is visible only through lookups, so a corrupted base, length, flag or rights bit shows up on the first request that names that entry. It appears one cycle later as a wrong sum or a wrong fault code. A wrong count register shows up as a code 2'b01 that should not be there, or is missing, at the boundary segment number. For this reason the stimulus probes that segment number and the offsets length-1 and length on purpose. A broken check order is visible only on requests that fail more than one check, so those requests are built directly. Writes that land on the same edge as a lookup expose any path that forwards the new data early.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SEG  = 2'b01,
    FLT_OFS  = 2'b10,
    FLT_PROT = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  localparam int PERM_W = 3;

  // Rights lookup: bit0 read, bit1 write, bit2 execute, reserved never allowed.
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_RD:  return perm[0];
      ACC_WR:  return perm[1];
      ACC_EX:  return perm[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int BASE_W = 16,
  parameter int LEN_W  = 16,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm
);

  logic [BASE_W-1:0] base_q  [NSEG];
  logic [LEN_W-1:0]  len_q   [NSEG];
  logic              valid_q [NSEG];
  logic [PERM_W-1:0] perm_q  [NSEG];
  logic [NSEG-1:0]   wr_hit;

  for (genvar g = 0; g < NSEG; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_idx == SEG_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        len_q[i]   <= '0;
        valid_q[i] <= 1'b0;
        perm_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        if (wr_hit[i]) begin
          base_q[i]  <= wr_base;
          len_q[i]   <= wr_len;
          valid_q[i] <= wr_valid;
          perm_q[i]  <= wr_perm;
        end
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_len   = '0;
    rd_valid = 1'b0;
    rd_perm  = '0;
    if (int'(rd_idx) < NSEG) begin
      rd_base  = base_q[rd_idx];
      rd_len   = len_q[rd_idx];
      rd_valid = valid_q[rd_idx];
      rd_perm  = perm_q[rd_idx];
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 3,
  parameter int BASE_W = 16,
  parameter int LEN_W  = 16,
  localparam int TL_W  = SEG_W + 1,
  localparam int PA_W  = BASE_W + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [LEN_W-1:0]  ofs,
  input  logic [1:0]        acc,
  input  logic [TL_W-1:0]   tlen,
  input  logic [BASE_W-1:0] e_base,
  input  logic [LEN_W-1:0]  e_len,
  input  logic              e_valid,
  input  logic [PERM_W-1:0] e_perm,
  output logic [1:0]        fault,
  output logic [PA_W-1:0]   paddr,
  output logic              ev_seg_oob,
  output logic              ev_seg_inval,
  output logic              ev_ofs_over,
  output logic              ev_perm_deny
);

  function automatic logic [PA_W-1:0] phys_sum(input logic [BASE_W-1:0] b,
                                               input logic [LEN_W-1:0] o);
    return PA_W'(b) + PA_W'(o);
  endfunction

  assign ev_seg_oob   = TL_W'(seg) >= tlen;
  assign ev_seg_inval = !e_valid;
  assign ev_ofs_over  = ofs >= e_len;
  assign ev_perm_deny = !perm_allows(e_perm, acc);

  always_comb begin
    if (ev_seg_oob || ev_seg_inval) fault = FLT_SEG;
    else if (ev_ofs_over)           fault = FLT_OFS;
    else if (ev_perm_deny)          fault = FLT_PROT;
    else                            fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? phys_sum(e_base, ofs) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int BASE_W = 16,
  parameter int LEN_W  = 16,
  localparam int SEG_W = $clog2(NSEG),
  localparam int TL_W  = SEG_W + 1,
  localparam int PA_W  = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_we,
  input  logic [SEG_W-1:0]  ent_idx,
  input  logic [BASE_W-1:0] ent_base,
  input  logic [LEN_W-1:0]  ent_len,
  input  logic              ent_valid,
  input  logic [2:0]        ent_perm,
  input  logic              tlen_we,
  input  logic [TL_W-1:0]   tlen_val,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [LEN_W-1:0]  req_ofs,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault
);

  logic [TL_W-1:0]   tlen_q;
  logic [BASE_W-1:0] e_base;
  logic [LEN_W-1:0]  e_len;
  logic              e_valid;
  logic [PERM_W-1:0] e_perm;
  logic [1:0]        chk_fault;
  logic [PA_W-1:0]   chk_paddr;
  logic              ev_seg_oob;
  logic              ev_seg_inval;
  logic              ev_ofs_over;
  logic              ev_perm_deny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tlen_q <= '0;
    else if (tlen_we) tlen_q <= tlen_val;
  end

  seg_table #(.NSEG(NSEG), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ent_we), .wr_idx(ent_idx), .wr_base(ent_base), .wr_len(ent_len),
    .wr_valid(ent_valid), .wr_perm(ent_perm),
    .rd_idx(req_seg),
    .rd_base(e_base), .rd_len(e_len), .rd_valid(e_valid), .rd_perm(e_perm)
  );

  seg_check #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_chk_logic (
    .seg(req_seg), .ofs(req_ofs), .acc(req_acc), .tlen(tlen_q),
    .e_base(e_base), .e_len(e_len), .e_valid(e_valid), .e_perm(e_perm),
    .fault(chk_fault), .paddr(chk_paddr),
    .ev_seg_oob(ev_seg_oob), .ev_seg_inval(ev_seg_inval),
    .ev_ofs_over(ev_ofs_over), .ev_perm_deny(ev_perm_deny)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else if (req_valid) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= chk_paddr;
      rsp_fault <= chk_fault;
    end else begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            ev_seg_oob,
  input logic            ev_seg_inval,
  input logic            ev_ofs_over
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'b00 && rsp_paddr == '0));

  // R4
  seg_oob_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_seg_oob) |=> rsp_fault == 2'b01);

  // R8
  ofs_before_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ev_seg_oob && !ev_seg_inval && ev_ofs_over) |=> rsp_fault == 2'b10);

  // R9
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .ev_seg_oob(ev_seg_oob), .ev_seg_inval(ev_seg_inval), .ev_ofs_over(ev_ofs_over)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int CLK_P = 10;
  localparam int NSEG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ent_we = 1'b0;
  logic [2:0]  ent_idx = '0;
  logic [15:0] ent_base = '0;
  logic [15:0] ent_len = '0;
  logic        ent_valid = 1'b0;
  logic [2:0]  ent_perm = '0;
  logic        tlen_we = 1'b0;
  logic [3:0]  tlen_val = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [15:0] req_ofs = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [16:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int m_base [NSEG];
  int m_len  [NSEG];
  bit m_vld  [NSEG];
  bit [2:0] m_perm [NSEG];
  int m_tlen = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_xlate u0 (.*);

  // Expected {fault, paddr} built from the requirements.
  function automatic bit [18:0] expect_rsp(int seg, int ofs, int acc);
    bit ok_right;
    if (seg >= m_tlen || !m_vld[seg]) return {2'b01, 17'd0};
    if (!(ofs < m_len[seg])) return {2'b10, 17'd0};
    ok_right = (acc == 0) ? m_perm[seg][0] :
               (acc == 1) ? m_perm[seg][1] :
               (acc == 2) ? m_perm[seg][2] : 1'b0;
    if (!ok_right) return {2'b11, 17'd0};
    return {2'b00, 17'(m_base[seg] + ofs)};
  endfunction

  task automatic check(string tag, bit [18:0] got, bit [18:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got fault=%b addr=%0d expected fault=%b addr=%0d",
               tag, got[18:17], got[16:0], exp[18:17], exp[16:0]);
    end
  endtask

  task automatic put_entry(int idx, int base, int len, bit v, bit [2:0] p);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 3'(idx); ent_base = 16'(base);
    ent_len = 16'(len); ent_valid = v; ent_perm = p;
    @(posedge clk); #1;
    ent_we = 1'b0;
    m_base[idx] = base; m_len[idx] = len; m_vld[idx] = v; m_perm[idx] = p;
  endtask

  task automatic put_tlen(int n);
    @(negedge clk);
    tlen_we = 1'b1; tlen_val = 4'(n);
    @(posedge clk); #1;
    tlen_we = 1'b0;
    m_tlen = n;
  endtask

  task automatic lookup(int seg, int ofs, int acc, string tag);
    bit [18:0] exp;
    string t;
    @(negedge clk);
    exp = expect_rsp(seg, ofs, acc);
    req_valid = 1'b1; req_seg = 3'(seg); req_ofs = 16'(ofs); req_acc = 2'(acc);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (tag != "") t = tag;
    else case (exp[18:17])
      2'b00: t = "R3";
      2'b01: t = "R4/R5";
      2'b10: t = "R6";
      default: t = "R7";
    endcase
    check({t, " valid"}, {18'd0, rsp_valid}, 19'd1);
    check(t, {rsp_fault, rsp_paddr}, exp);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    @(posedge clk); #1;
    check("R2 idle", {rsp_valid, rsp_fault, rsp_paddr}[18:0], 19'd0);
    check("R2 idle valid", {18'd0, rsp_valid}, 19'd0);
  endtask

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = 0; m_len[i] = 0; m_vld[i] = 1'b0; m_perm[i] = '0;
    end
    void'($urandom(32'd4417));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset outputs", {rsp_valid, rsp_fault, rsp_paddr}[18:0], 19'd0);
    check("R1 reset valid", {18'd0, rsp_valid}, 19'd0);
    lookup(0, 0, 0, "R1");
    put_tlen(8);
    lookup(3, 0, 0, "R1 invalid after reset");

    put_entry(1, 2300, 14, 1, 3'b111);
    put_entry(2, 90, 100, 1, 3'b111);
    put_entry(3, 1327, 580, 1, 3'b101);
    lookup(2, 0, 0, "R3");
    lookup(1, 100, 0, "R6");
    lookup(3, 580, 0, "R6");
    lookup(3, 579, 2, "R3");
    lookup(3, 10, 1, "R7");
    lookup(2, 5, 3, "R7");
    put_entry(4, 16'hFFFF, 16'hFFFF, 1, 3'b001);
    lookup(4, 16'hFFFE, 0, "R3 wide sum");

    put_tlen(4);
    lookup(4, 0, 0, "R4");
    lookup(3, 0, 0, "R4 boundary");
    put_tlen(8);
    put_entry(5, 50, 10, 0, 3'b000);
    lookup(5, 999, 1, "R8 seg first");
    lookup(3, 700, 1, "R8 ofs first");
    lookup(5, 0, 0, "R5");
    idle_cycle();

    // Write and lookup on the same edge: lookup must see old entry.
    put_entry(6, 100, 10, 1, 3'b111);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 3'd6; ent_base = 16'd500; ent_len = 16'd10;
    ent_valid = 1'b1; ent_perm = 3'b111;
    req_valid = 1'b1; req_seg = 3'd6; req_ofs = 16'd3; req_acc = 2'd0;
    @(posedge clk); #1;
    ent_we = 1'b0; req_valid = 1'b0;
    check("R10 old data", {rsp_fault, rsp_paddr}, {2'b00, 17'd103});
    m_base[6] = 500;
    lookup(6, 3, 0, "R10 new data");

    for (int k = 0; k < 400; k++) begin
      int r;
      int s;
      int o;
      r = int'($urandom % 100);
      s = int'($urandom % NSEG);
      if (r < 15) begin
        put_entry(s, int'($urandom % 65536), int'($urandom % 300),
                  ($urandom % 5) != 0, 3'($urandom));
      end else if (r < 19) begin
        put_tlen(int'($urandom % 9));
      end else if (r < 24) begin
        idle_cycle();
      end else begin
        case ($urandom % 3)
          0: o = int'($urandom % 65536);
          1: o = (m_len[s] > 0) ? m_len[s] - 1 : 0;
          default: o = m_len[s];
        endcase
        lookup(s, o & 16'hFFFF, int'($urandom % 4), "");
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule